// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is the transmit half of a UART-style port, bundled with the 8-bit control register that governs it. Software writes a data word into a holding buffer. At each one-cycle bit strobe from an external baud generator, the block moves that word into a shift register and sends it on a single output line. It sends a low start bit first, then the data bits least significant bit first, then a high stop bit. Three format inputs select 8 or 9 data bits and an optional even or odd parity bit. When parity is on, the parity bit takes the place of the highest data bit, so a frame is always 10 or 11 bits long.

Two status flags report progress: one says the holding buffer is empty, the other says the line has gone quiet with nothing left to send. Each flag has its own enable bit in the control register. A single interrupt request is raised when either enabled flag is set. The control register can also order a break, which fills the line with all-zero frames, and it can switch the transmitter off. It stores the receive-side enables and the receiver wakeup bit and passes them out unchanged for a receiver elsewhere.

Top module: `uart_tx_core`

## Requirements
- R1: The control register is written whole through `ctrl_we`/`ctrl_wdata` and read back on `ctrl_q`. Its bits, from 7 down to 0, are: buffer-empty interrupt enable, complete interrupt enable, receive-full interrupt enable, idle-line interrupt enable, transmitter enable, receiver enable, receiver wakeup, send break. Bits 5, 4, 2 and 1 appear unchanged on `rx_full_ie`, `idle_ie`, `rx_en` and `rx_wake`.
- R2: After reset, `ctrl_q` is 0, `txd` is 1, `tx_empty` is 1, `tx_done` is 1 and `tx_irq` is 0.
- R3: With `fmt_wide`=0 and `par_en`=0, a frame is a 0 start bit, 8 data bits and a 1 stop bit: 10 bits.
- R4: With `fmt_wide`=1 and `par_en`=0, a frame is a start bit, 9 data bits and a stop bit: 11 bits.
- R5: With `par_en`=1, the data bits sent are 7 (`fmt_wide`=0) or 8 (`fmt_wide`=1), followed by a parity bit in the top data position. `par_odd`=0 makes the number of ones over the data bits plus parity even; `par_odd`=1 makes it odd.
- R6: Each frame bit lasts exactly one `bit_tick`. The first strobe with data buffered and the transmitter idle puts the start bit on `txd`, and data leave least significant bit first. `txd` changes only at a clock edge where `bit_tick` is 1.
- R7: `tx_irq` is 1 exactly when (`tx_empty` and bit 7) or (`tx_done` and bit 6).
- R8: A buffer write clears `tx_empty` on the next cycle. `tx_empty` sets when the buffered word moves into the shifter, which is at the strobe that sends its start bit.
- R9: A buffer write clears `tx_done`. `tx_done` sets at the strobe that ends a frame's stop bit when no word is buffered, and the line then stays at 1.
- R10: While send break and transmitter enable are both 1, whole frames of all zeros, of the current frame length, are sent back to back. Buffered data wait.
- R11: After send break is cleared, the line is 1 for at least one bit period before the next start bit.
- R12: Clearing transmitter enable lets the frame in progress finish. The line then stays at 1 and buffered data are not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| ctrl_q | output | 8 | Control register contents |
| fmt_wide | input | 1 | 0: 10-bit frame, 1: 11-bit frame |
| par_en | input | 1 | Parity bit replaces the top data bit |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| buf_we | input | 1 | Holding buffer write strobe |
| buf_wdata | input | BASE_W+1 | Word to send (upper bits unused when narrow) |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| txd | output | 1 | Serial line, idles at 1 |
| tx_empty | output | 1 | Holding buffer empty flag |
| tx_done | output | 1 | Transmission complete flag |
| tx_irq | output | 1 | Transmitter interrupt request |
| rx_full_ie | output | 1 | Stored receive-full interrupt enable |
| idle_ie | output | 1 | Stored idle-line interrupt enable |
| rx_en | output | 1 | Stored receiver enable |
| rx_wake | output | 1 | Stored receiver wakeup bit |

## Verification
The bench builds the block with its default `BASE_W` of 8, so all four character formats and both frame lengths can be tested. Every frame is sent at bit strobes spaced one cycle apart, which lets the bench compare whole 10- and 11-bit frames quickly. The boundary moments fall within a few strobes: the start-bit strobe that empties the buffer, the strobe after the stop bit that sets the complete flag, the seam between two break frames, and the mandatory high bit after a break.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef struct packed {
        logic empty_ie;
        logic done_ie;
        logic rxfull_ie;
        logic idle_ie;
        logic tx_en;
        logic rx_en;
        logic rx_wake;
        logic brk;
    } ctl_t;

    typedef struct packed {
        logic wide;
        logic par_en;
        logic par_odd;
    } fmt_t;

    typedef enum logic [1:0] {
        PICK_IDLE,
        PICK_DATA,
        PICK_BREAK
    } pick_e;

endpackage

// File: rtl/uart_tx_ctlreg.sv
module uart_tx_ctlreg
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctl_t       ctl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (we)
            ctl <= ctl_t'(wdata);
    end
endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (we) begin
            full <= 1'b1;
            data <= wdata;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            tx_en,
    input  logic            brk,
    input  fmt_t            fmt,
    input  logic            buf_full,
    input  logic [BASE_W:0] buf_data,
    output logic            take,
    output logic            idle_pulse,
    output logic            txd
);
    localparam int FR_W  = BASE_W + 3;
    localparam int CNT_W = $clog2(FR_W);

    logic [FR_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic             brk_prev;

    logic [FR_W-1:0]  frame_d;
    logic [CNT_W-1:0] last_idx;
    logic             par;
    int               nbits;
    logic             frame_over;
    pick_e            pick;

    // Frame assembly from the buffered word and the format inputs
    always_comb begin
        nbits = fmt.wide ? BASE_W + 1 : BASE_W;
        par   = fmt.par_odd;
        for (int i = 0; i < BASE_W + 1; i++)
            if (i < nbits - 1)
                par = par ^ buf_data[i];
        frame_d    = '1;
        frame_d[0] = 1'b0;
        for (int i = 0; i < BASE_W + 1; i++)
            if (i < nbits)
                frame_d[i+1] = (fmt.par_en && i == nbits - 1) ? par : buf_data[i];
        last_idx = CNT_W'(nbits + 1);
    end

    // Choice made at a frame boundary
    always_comb begin
        frame_over = !busy || (cnt == '0);
        if (tx_en && brk)
            pick = PICK_BREAK;
        else if (tx_en && buf_full && !brk_prev)
            pick = PICK_DATA;
        else
            pick = PICK_IDLE;
        take       = tick && frame_over && (pick == PICK_DATA);
        idle_pulse = tick && frame_over && busy && (pick == PICK_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '1;
            cnt      <= '0;
            busy     <= 1'b0;
            txd      <= 1'b1;
            brk_prev <= 1'b0;
        end else if (tick) begin
            if (frame_over) begin
                case (pick)
                    PICK_BREAK: begin
                        sh       <= '0;
                        cnt      <= last_idx;
                        busy     <= 1'b1;
                        txd      <= 1'b0;
                        brk_prev <= 1'b1;
                    end
                    PICK_DATA: begin
                        sh   <= {1'b1, frame_d[FR_W-1:1]};
                        cnt  <= last_idx;
                        busy <= 1'b1;
                        txd  <= frame_d[0];
                    end
                    default: begin
                        busy     <= 1'b0;
                        txd      <= 1'b1;
                        brk_prev <= 1'b0;
                    end
                endcase
            end else begin
                txd <= sh[0];
                sh  <= {1'b1, sh[FR_W-1:1]};
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctrl_we,
    input  logic [7:0]      ctrl_wdata,
    output logic [7:0]      ctrl_q,
    input  logic            fmt_wide,
    input  logic            par_en,
    input  logic            par_odd,
    input  logic            buf_we,
    input  logic [BASE_W:0] buf_wdata,
    input  logic            bit_tick,
    output logic            txd,
    output logic            tx_empty,
    output logic            tx_done,
    output logic            tx_irq,
    output logic            rx_full_ie,
    output logic            idle_ie,
    output logic            rx_en,
    output logic            rx_wake
);
    ctl_t            ctl;
    fmt_t            fmt;
    logic            buf_full;
    logic [BASE_W:0] buf_data;
    logic            take;
    logic            idle_pulse;
    logic            done_q;

    assign fmt = '{wide: fmt_wide, par_en: par_en, par_odd: par_odd};

    uart_tx_ctlreg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .ctl   (ctl)
    );

    uart_tx_holdbuf #(.W(BASE_W + 1)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .we    (buf_we),
        .wdata (buf_wdata),
        .take  (take),
        .full  (buf_full),
        .data  (buf_data)
    );

    uart_tx_shifter #(.BASE_W(BASE_W)) u_shf (
        .clk        (clk),
        .rst        (rst),
        .tick       (bit_tick),
        .tx_en      (ctl.tx_en),
        .brk        (ctl.brk),
        .fmt        (fmt),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .take       (take),
        .idle_pulse (idle_pulse),
        .txd        (txd)
    );

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b1;
        else if (buf_we)
            done_q <= 1'b0;
        else if (idle_pulse && !buf_full)
            done_q <= 1'b1;
    end

    assign ctrl_q     = ctl;
    assign tx_empty   = !buf_full;
    assign tx_done    = done_q;
    assign tx_irq     = (ctl.empty_ie && tx_empty) || (ctl.done_ie && tx_done);
    assign rx_full_ie = ctl.rxfull_ie;
    assign idle_ie    = ctl.idle_ie;
    assign rx_en      = ctl.rx_en;
    assign rx_wake    = ctl.rx_wake;
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] ctrl_q,
    input logic       buf_we,
    input logic       bit_tick,
    input logic       txd,
    input logic       tx_empty,
    input logic       tx_done,
    input logic       tx_irq
);
    // R2
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_q == 8'h00 && txd && tx_empty && tx_done && !tx_irq));

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(txd));

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[7] && !ctrl_q[6]) |-> !tx_irq);

    // R8
    buf_write_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> (!tx_empty && !tx_done));

    // R9
    done_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> tx_empty);
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl_q   (ctrl_q),
    .buf_we   (buf_we),
    .bit_tick (bit_tick),
    .txd      (txd),
    .tx_empty (tx_empty),
    .tx_done  (tx_done),
    .tx_irq   (tx_irq)
);

// File: tb/uart_tx_core_test.sv
module uart_tx_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_q;
    logic       fmt_wide = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       buf_we = 1'b0;
    logic [8:0] buf_wdata = '0;
    logic       bit_tick = 1'b0;
    logic       txd, tx_empty, tx_done, tx_irq;
    logic       rx_full_ie, idle_ie, rx_en, rx_wake;

    int checks = 0;
    int failures = 0;

    uart_tx_core uut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .fmt_wide(fmt_wide), .par_en(par_en), .par_odd(par_odd),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .bit_tick(bit_tick), .txd(txd),
        .tx_empty(tx_empty), .tx_done(tx_done), .tx_irq(tx_irq),
        .rx_full_ie(rx_full_ie), .idle_ie(idle_ie), .rx_en(rx_en), .rx_wake(rx_wake)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ctrl_we = 1'b0; buf_we = 1'b0; bit_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic write_buf(input logic [8:0] v);
        @(negedge clk);
        buf_we = 1'b1; buf_wdata = v;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    // Expected frame, bit i is the i-th bit on the line
    function automatic logic [10:0] exp_frame(input logic [8:0] d, input bit wide, input bit pe, input bit po);
        logic [10:0] f;
        int nd;
        logic [8:0] mask;
        logic p;
        nd = wide ? 9 : 8;
        if (pe) nd = nd - 1;
        mask = 9'((1 << nd) - 1);
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) f[i+1] = d[i];
        if (pe) begin
            p = ($countones(d & mask) % 2 == 1) ? 1'b1 : 1'b0;
            if (po) p = ~p;
            f[nd+1] = p;
        end
        return f;
    endfunction

    task automatic capture(input int len, output logic [10:0] got);
        got = '1;
        for (int i = 0; i < len; i++) begin
            tick();
            got[i] = txd;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(ctrl_q == 8'h00, "R2 ctrl", ctrl_q, 0);
        chk(txd && tx_empty && tx_done && !tx_irq, "R2 flags",
            {txd, tx_empty, tx_done, tx_irq}, 4'b1110);
    endtask

    task automatic t_ctl();
        do_reset();
        write_ctl(8'hA6);
        chk(ctrl_q == 8'hA6, "R1 readback", ctrl_q, 8'hA6);
        chk({rx_full_ie, idle_ie, rx_en, rx_wake} == 4'b1011, "R1 passout",
            {rx_full_ie, idle_ie, rx_en, rx_wake}, 4'b1011);
        do_reset();
        chk(ctrl_q == 8'h00, "R2 clears ctrl", ctrl_q, 0);
    endtask

    task automatic t_frame(input logic [8:0] d, input bit wide, input bit pe, input bit po, input string req);
        logic [10:0] e, got;
        int len;
        do_reset();
        fmt_wide = wide; par_en = pe; par_odd = po;
        len = wide ? 11 : 10;
        e = exp_frame(d, wide, pe, po);
        write_ctl(8'h08);
        write_buf(d);
        chk(!tx_empty && !tx_done, "R8 write clears flags", {tx_empty, tx_done}, 0);
        chk(txd == 1'b1, "R6 idle before strobe", txd, 1);
        got = '1;
        tick();
        got[0] = txd;
        chk(tx_empty, "R8 empty at start bit", tx_empty, 1);
        for (int i = 1; i < len; i++) begin
            tick();
            got[i] = txd;
        end
        chk(got == e, req, got, e);
        chk(!tx_done, "R9 not done during stop", tx_done, 0);
        tick();
        chk(tx_done && txd, "R9 done after stop", {tx_done, txd}, 2'b11);
    endtask

    task automatic t_irq();
        do_reset();
        write_ctl(8'h80);
        chk(tx_irq, "R7 empty enabled", tx_irq, 1);
        write_ctl(8'h40);
        chk(tx_irq, "R7 done enabled", tx_irq, 1);
        write_ctl(8'h30);
        chk(!tx_irq, "R7 both masked", tx_irq, 0);
        write_ctl(8'hC0);
        write_buf(9'h012);
        chk(!tx_irq, "R7 flags clear", tx_irq, 0);
    endtask

    task automatic t_break();
        logic [10:0] got, e;
        logic allz;
        do_reset();
        fmt_wide = 1'b0; par_en = 1'b0; par_odd = 1'b0;
        write_buf(9'h03C);
        write_ctl(8'h09);
        allz = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (txd !== 1'b0) allz = 1'b0;
        end
        chk(allz, "R10 two zero frames", allz, 1);
        chk(!tx_empty, "R10 data waits", tx_empty, 0);
        write_ctl(8'h08);
        tick();
        chk(txd == 1'b1, "R11 mark after break", txd, 1);
        e = exp_frame(9'h03C, 1'b0, 1'b0, 1'b0);
        capture(10, got);
        chk(got == e, "R11 data after break", got, e);
    endtask

    task automatic t_disable();
        logic [10:0] got, e;
        logic allhi;
        do_reset();
        fmt_wide = 1'b0; par_en = 1'b0; par_odd = 1'b0;
        write_buf(9'h055);
        allhi = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (txd !== 1'b1) allhi = 1'b0;
        end
        chk(allhi && !tx_empty, "R12 disabled line idle", {allhi, tx_empty}, 2'b10);
        write_ctl(8'h08);
        got = '1;
        for (int i = 0; i < 3; i++) begin
            tick();
            got[i] = txd;
        end
        write_ctl(8'h00);
        write_buf(9'h00F);
        for (int i = 3; i < 10; i++) begin
            tick();
            got[i] = txd;
        end
        e = exp_frame(9'h055, 1'b0, 1'b0, 1'b0);
        chk(got == e, "R12 frame finishes", got, e);
        allhi = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (txd !== 1'b1) allhi = 1'b0;
        end
        chk(allhi && !tx_empty, "R12 buffered ignored", {allhi, tx_empty}, 2'b10);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_ctl();
        t_frame(9'h0A5, 1'b0, 1'b0, 1'b0, "R3 narrow frame");
        t_frame(9'h1C3, 1'b1, 1'b0, 1'b0, "R4 wide frame");
        t_frame(9'h0B3, 1'b0, 1'b1, 1'b0, "R5 narrow even");
        t_frame(9'h0B3, 1'b0, 1'b1, 1'b1, "R5 narrow odd");
        t_frame(9'h0E1, 1'b1, 1'b1, 1'b1, "R5 wide odd");
        t_frame(9'h1D6, 1'b1, 1'b1, 1'b0, "R5 wide even");
        t_frame(9'h001, 1'b0, 1'b0, 1'b0, "R6 lsb first");
        t_irq();
        t_break();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule